// File: doc/BRIEF.md
# Byte-Metered Pixel FIFO with Fetch Throttle

This block sits between a compositor that produces pixels and a display timing generator that consumes them. Pixels arrive on a valid/ready stream and are stored together with a tag for their format. The consumer pops one pixel on each active clock. Occupancy is kept in two-bit slices, so a 16-bit pixel counts as 2 bytes, an 18-bit packed pixel as 2.25 bytes and a 24-bit pixel as 3 bytes. A fetch request goes to the supplier while the stored byte count, rounded up, is below a full level.

The supplier may deliver up to six more pixels after the request drops. For that reason the full level can be derived from the active format, leaving six pixels of headroom plus one spare byte for 24-bit formats. Software may instead program the level through a low field and a separate high field. Other features are a FIFO clear that works only while the block is disabled, an optional flush on the frame-start strobe, an option to hold output until the first horizontal start, sticky overflow and underflow flags, and an optional one-cycle underflow event.

Top module: `pixel_fetch_fifo`

## Requirements
- R1: After reset, fetch_req, in_ready, ovf_flag, unf_flag and unf_pulse are 0 and out_pix equals the fill value FILL_PIX.
- R2: Pixels leave on out_pix in the order they were accepted, with their data unchanged. out_pix updates at the clock edge that samples pop and holds its value when pop is low.
- R3: Each pixel's size comes from cfg_fmt at the time it is pushed: 0 = 16-bit, 8 slices; 1 = 18-bit packed, 9 slices; 2 and 3 = 24-bit, 12 slices. One slice is a quarter byte. fetch_req = en AND (ceil(slices/4) < full level).
- R4: With cfg_lvl_auto = 1, the full level is DEPTH_BYTES−12 for format 0, DEPTH_BYTES−14 for format 1, and DEPTH_BYTES−19 for formats 2 and 3.
- R5: With cfg_lvl_auto = 0, the full level is {cfg_lvl_hi, cfg_lvl_lo}. cfg_lvl_lo holds level bits 5:0 and cfg_lvl_hi holds the bits above bit 5.
- R6: A push is dropped if the stored slices plus the new pixel's slices would exceed 4·DEPTH_BYTES. A dropped push sets ovf_flag, which then stays set.
- R7: A pop that is honoured while the FIFO is empty is an underflow. It returns FILL_PIX, sets unf_flag (which stays set) and leaves the contents unchanged.
- R8: unf_pulse is high for exactly the cycle after an underflow, and only if cfg_unf_trig was 1 at that edge.
- R9: fifo_clr empties the FIFO and clears both sticky flags only while en = 0. While en = 1 it has no effect.
- R10: If cfg_clr_sof = 1, frame_start empties the FIFO in that cycle and the flags are kept. If cfg_clr_sof = 0, frame_start has no effect. A clear takes priority over a push or pop in the same cycle: the push is dropped and the pop returns FILL_PIX.
- R11: If cfg_wait_hs = 1, pops after enable return FILL_PIX without consuming and without underflow until hstart is seen. Pops are honoured from the cycle after that.
- R12: While en = 0, in_ready is 0, pushes are ignored, and pops return FILL_PIX without consuming or flagging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| cfg_fmt | input | 2 | Format of pixels being pushed |
| cfg_lvl_auto | input | 1 | Derive the full level from the format |
| cfg_lvl_lo | input | 6 | Manual full level, bits 5:0 |
| cfg_lvl_hi | input | LVL_HI_W | Manual full level, bits above 5 |
| cfg_clr_sof | input | 1 | Flush on frame start |
| cfg_wait_hs | input | 1 | Hold output until horizontal start |
| cfg_unf_trig | input | 1 | Enable the underflow event pulse |
| fifo_clr | input | 1 | Clear contents and flags (honoured only while disabled) |
| frame_start | input | 1 | Frame-start strobe |
| hstart | input | 1 | Horizontal-start strobe |
| in_valid | input | 1 | Supplier pixel valid |
| in_pix | input | PIX_W | Supplier pixel |
| in_ready | output | 1 | Block accepts pixels |
| fetch_req | output | 1 | Request more pixels |
| pop | input | 1 | Consumer takes one pixel |
| out_pix | output | PIX_W | Pixel delivered to the consumer |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |
| unf_pulse | output | 1 | One-cycle underflow event |

## Verification
The assertions assume that every control input and strobe is a clean synchronous level, sampled once per clock, and that rst_n stays low long enough for the internal reset synchronizer to settle. They also take fifo_clr to be a software action that is meaningful only while en is low. The stimulus applies all inputs half a cycle away from the active edge and keeps reset low for several cycles. Random stimulus raises the enable, clear and frame-start controls only rarely, so long runs of push and pop build up real occupancy between those events.

// File: rtl/pff_pkg.sv
package pff_pkg;

  typedef enum logic [1:0] {
    PF_RGB16  = 2'd0,
    PF_RGB18P = 2'd1,
    PF_RGB24  = 2'd2,
    PF_RGB24S = 2'd3
  } pix_fmt_e;

  localparam int FMT_W = 2;

  // storage cost of one pixel in quarter-byte slices
  function automatic logic [3:0] slices_of(input pix_fmt_e f);
    case (f)
      PF_RGB16:  slices_of = 4'd8;
      PF_RGB18P: slices_of = 4'd9;
      default:   slices_of = 4'd12;
    endcase
  endfunction

  // bytes kept free below depth: six pixels in flight, 24-bit keeps one spare
  function automatic logic [4:0] headroom_of(input pix_fmt_e f);
    case (f)
      PF_RGB16:  headroom_of = 5'd12;
      PF_RGB18P: headroom_of = 5'd14;
      default:   headroom_of = 5'd19;
    endcase
  endfunction

endpackage

// File: rtl/pff_store.sv
module pff_store #(
  parameter int PIX_W   = 24,
  parameter int ENTRIES = 32,
  localparam int DW     = PIX_W + pff_pkg::FMT_W,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CW     = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [ENTRIES];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(ENTRIES - 1)) bump = '0;
    else                       bump = p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (wr_en) wr_ptr_d = bump(wr_ptr_q);
      if (rd_en) rd_ptr_d = bump(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_data = mem[rd_ptr_q];
  assign count   = cnt_q;

endmodule

// File: rtl/pff_level.sv
module pff_level #(
  parameter int DEPTH_BYTES = 64,
  parameter int LVL_W       = 7,
  parameter int SU_W        = 9,
  localparam int CMP_W      = (SU_W + 1 > LVL_W) ? SU_W + 1 : LVL_W
) (
  input  logic             en,
  input  pff_pkg::pix_fmt_e fmt,
  input  logic             lvl_auto,
  input  logic [LVL_W-1:0] lvl_man,
  input  logic [SU_W-1:0]  occ_units,
  output logic             fetch_req
);
  import pff_pkg::*;

  logic [LVL_W-1:0] lvl_auto_val;
  logic [LVL_W-1:0] level;
  logic [SU_W:0]    rounded;
  logic [SU_W:0]    occ_bytes;

  always_comb begin
    lvl_auto_val = LVL_W'(DEPTH_BYTES) - LVL_W'(headroom_of(fmt));
    level        = lvl_auto ? lvl_auto_val : lvl_man;
    rounded      = {1'b0, occ_units} + (SU_W + 1)'(3);
    occ_bytes    = rounded >> 2;
    fetch_req    = en && (CMP_W'(occ_bytes) < CMP_W'(level));
  end

endmodule

// File: rtl/pff_ctrl.sv
module pff_ctrl #(
  parameter int              PIX_W     = 24,
  parameter int              ENTRIES   = 32,
  parameter int              CAP_UNITS = 256,
  parameter int              SU_W      = 9,
  parameter logic [PIX_W-1:0] FILL_PIX = '0,
  localparam int DW = PIX_W + pff_pkg::FMT_W,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en,
  input  pff_pkg::pix_fmt_e fmt,
  input  logic              clr_sw,
  input  logic              sof,
  input  logic              clr_sof_en,
  input  logic              wait_hs,
  input  logic              unf_trig,
  input  logic              hstart,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              pop,
  input  logic [CW-1:0]     st_count,
  input  logic [DW-1:0]     st_rd_data,
  output logic              st_flush,
  output logic              st_wr_en,
  output logic [DW-1:0]     st_wr_data,
  output logic              st_rd_en,
  output logic [SU_W-1:0]   occ_units,
  output logic [PIX_W-1:0]  out_pix,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              unf_pulse
);
  import pff_pkg::*;

  logic [SU_W-1:0]  occ_q, occ_d;
  logic [PIX_W-1:0] out_q, out_d;
  logic             ovf_q, ovf_d, unf_q, unf_d, pls_q, pls_d, arm_q, arm_d;
  logic             sw_clear, gate, take, empty, push_try, fits;
  logic [3:0]       in_units, head_units;
  logic [SU_W:0]    occ_plus;
  pix_fmt_e         head_fmt;

  always_comb begin
    sw_clear   = !en && clr_sw;
    st_flush   = sw_clear || (clr_sof_en && sof);
    gate       = en && (arm_q || !wait_hs);
    take       = pop && gate && !st_flush;
    empty      = (st_count == '0);
    st_rd_en   = take && !empty;
    head_fmt   = pix_fmt_e'(st_rd_data[DW-1:PIX_W]);
    head_units = slices_of(head_fmt);
    in_units   = slices_of(fmt);
    occ_plus   = {1'b0, occ_q} + (SU_W + 1)'(in_units);
    fits       = occ_plus <= (SU_W + 1)'(CAP_UNITS);
    push_try   = in_valid && en && !st_flush;
    st_wr_en   = push_try && fits;
    st_wr_data = {fmt, in_pix};
  end

  always_comb begin
    if (st_flush) occ_d = '0;
    else occ_d = occ_q + (st_wr_en ? SU_W'(in_units) : '0)
                       - (st_rd_en ? SU_W'(head_units) : '0);
    ovf_d = sw_clear ? 1'b0 : (ovf_q || (push_try && !fits));
    unf_d = sw_clear ? 1'b0 : (unf_q || (take && empty));
    pls_d = take && empty && unf_trig;
    if (!en)         arm_d = 1'b0;
    else if (hstart) arm_d = 1'b1;
    else             arm_d = arm_q;
    out_d = st_rd_en ? st_rd_data[PIX_W-1:0] : FILL_PIX;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      pls_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      occ_q <= occ_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      pls_q <= pls_d;
      arm_q <= arm_d;
    end
  end

  // output register loads only on a pop (clock enable)
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  out_q <= FILL_PIX;
    else if (pop) out_q <= out_d;
  end

  assign occ_units = occ_q;
  assign out_pix   = out_q;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;
  assign unf_pulse = pls_q;

endmodule

// File: rtl/pixel_fetch_fifo.sv
module pixel_fetch_fifo #(
  parameter int               PIX_W       = 24,
  parameter int               DEPTH_BYTES = 64,
  parameter logic [PIX_W-1:0] FILL_PIX    = 24'h108080,
  localparam int LVL_W     = $clog2(DEPTH_BYTES + 1),
  localparam int LVL_HI_W  = (LVL_W > 6) ? LVL_W - 6 : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [1:0]          cfg_fmt,
  input  logic                cfg_lvl_auto,
  input  logic [5:0]          cfg_lvl_lo,
  input  logic [LVL_HI_W-1:0] cfg_lvl_hi,
  input  logic                cfg_clr_sof,
  input  logic                cfg_wait_hs,
  input  logic                cfg_unf_trig,
  input  logic                fifo_clr,
  input  logic                frame_start,
  input  logic                hstart,
  input  logic                in_valid,
  input  logic [PIX_W-1:0]    in_pix,
  output logic                in_ready,
  output logic                fetch_req,
  input  logic                pop,
  output logic [PIX_W-1:0]    out_pix,
  output logic                ovf_flag,
  output logic                unf_flag,
  output logic                unf_pulse
);
  import pff_pkg::*;

  localparam int CAP_UNITS = DEPTH_BYTES * 4;
  localparam int ENTRIES   = DEPTH_BYTES / 2;
  localparam int SU_W      = $clog2(CAP_UNITS + 1);
  localparam int DW        = PIX_W + FMT_W;
  localparam int CW        = $clog2(ENTRIES + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  pix_fmt_e        fmt;
  logic            st_flush, st_wr_en, st_rd_en;
  logic [DW-1:0]   st_wr_data, st_rd_data;
  logic [CW-1:0]   st_count;
  logic [SU_W-1:0] occ_units;
  logic [LVL_W-1:0] lvl_man;

  assign fmt      = pix_fmt_e'(cfg_fmt);
  assign lvl_man  = LVL_W'({cfg_lvl_hi, cfg_lvl_lo});
  assign in_ready = en;

  pff_store #(.PIX_W(PIX_W), .ENTRIES(ENTRIES)) u_store (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .flush   (st_flush),
    .wr_en   (st_wr_en),
    .wr_data (st_wr_data),
    .rd_en   (st_rd_en),
    .rd_data (st_rd_data),
    .count   (st_count)
  );

  pff_ctrl #(
    .PIX_W(PIX_W), .ENTRIES(ENTRIES), .CAP_UNITS(CAP_UNITS),
    .SU_W(SU_W), .FILL_PIX(FILL_PIX)
  ) u_ctrl (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .en         (en),
    .fmt        (fmt),
    .clr_sw     (fifo_clr),
    .sof        (frame_start),
    .clr_sof_en (cfg_clr_sof),
    .wait_hs    (cfg_wait_hs),
    .unf_trig   (cfg_unf_trig),
    .hstart     (hstart),
    .in_valid   (in_valid),
    .in_pix     (in_pix),
    .pop        (pop),
    .st_count   (st_count),
    .st_rd_data (st_rd_data),
    .st_flush   (st_flush),
    .st_wr_en   (st_wr_en),
    .st_wr_data (st_wr_data),
    .st_rd_en   (st_rd_en),
    .occ_units  (occ_units),
    .out_pix    (out_pix),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag),
    .unf_pulse  (unf_pulse)
  );

  pff_level #(.DEPTH_BYTES(DEPTH_BYTES), .LVL_W(LVL_W), .SU_W(SU_W)) u_level (
    .en        (en),
    .fmt       (fmt),
    .lvl_auto  (cfg_lvl_auto),
    .lvl_man   (lvl_man),
    .occ_units (occ_units),
    .fetch_req (fetch_req)
  );

endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
  parameter int SU_W      = 9,
  parameter int CAP_UNITS = 256
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            en,
  input logic            fifo_clr,
  input logic            frame_start,
  input logic            cfg_clr_sof,
  input logic            fetch_req,
  input logic            ovf_flag,
  input logic            unf_flag,
  input logic            unf_pulse,
  input logic [SU_W-1:0] occ_units
);

  p_req_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |-> !fetch_req);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    occ_units <= SU_W'(CAP_UNITS));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_flag && !(!en && fifo_clr)) |=> ovf_flag);

  p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (unf_flag && !(!en && fifo_clr)) |=> unf_flag);

  p_pulse_flagged_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    unf_pulse |-> unf_flag);

  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en && fifo_clr) |=> (!ovf_flag && !unf_flag && occ_units == '0));

  p_sof_flush_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_clr_sof && frame_start) |=> (occ_units == '0));

endmodule

bind pixel_fetch_fifo pff_chk #(.SU_W(SU_W), .CAP_UNITS(CAP_UNITS)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .en          (en),
  .fifo_clr    (fifo_clr),
  .frame_start (frame_start),
  .cfg_clr_sof (cfg_clr_sof),
  .fetch_req   (fetch_req),
  .ovf_flag    (ovf_flag),
  .unf_flag    (unf_flag),
  .unf_pulse   (unf_pulse),
  .occ_units   (occ_units)
);

// File: tb/pixel_fetch_fifo_tb.sv
module pixel_fetch_fifo_tb;

  localparam int          DEPTH = 64;
  localparam int          CAP   = DEPTH * 4;
  localparam logic [23:0] FILL  = 24'h108080;

  logic clk, rst_n;
  logic en, cfg_lvl_auto, cfg_clr_sof, cfg_wait_hs, cfg_unf_trig;
  logic [1:0] cfg_fmt;
  logic [5:0] cfg_lvl_lo;
  logic [0:0] cfg_lvl_hi;
  logic fifo_clr, frame_start, hstart, in_valid, pop;
  logic [23:0] in_pix;
  logic in_ready, fetch_req, ovf_flag, unf_flag, unf_pulse;
  logic [23:0] out_pix;

  int vectors = 0;
  int misses  = 0;
  string ctx_tag = "R1";

  // bench model
  logic [25:0] mq[$];
  int          m_occ;
  bit          m_ovf, m_unf, m_pls, m_arm;
  logic [23:0] m_out;

  pixel_fetch_fifo #(.PIX_W(24), .DEPTH_BYTES(DEPTH), .FILL_PIX(FILL)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_fmt(cfg_fmt),
    .cfg_lvl_auto(cfg_lvl_auto), .cfg_lvl_lo(cfg_lvl_lo), .cfg_lvl_hi(cfg_lvl_hi),
    .cfg_clr_sof(cfg_clr_sof), .cfg_wait_hs(cfg_wait_hs), .cfg_unf_trig(cfg_unf_trig),
    .fifo_clr(fifo_clr), .frame_start(frame_start), .hstart(hstart),
    .in_valid(in_valid), .in_pix(in_pix), .in_ready(in_ready), .fetch_req(fetch_req),
    .pop(pop), .out_pix(out_pix), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .unf_pulse(unf_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int slices(input logic [1:0] f);
    case (f)
      2'd0: return 8;
      2'd1: return 9;
      default: return 12;
    endcase
  endfunction

  function automatic int level_now();
    if (cfg_lvl_auto) begin
      case (cfg_fmt)
        2'd0: return DEPTH - 12;
        2'd1: return DEPTH - 14;
        default: return DEPTH - 19;
      endcase
    end
    return {cfg_lvl_hi, cfg_lvl_lo};
  endfunction

  function automatic bit exp_req();
    if (!en) return 1'b0;
    return ((m_occ + 3) / 4) < level_now();
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s (%s) at %0t: actual %0h expected %0h", tag, ctx_tag, $time, act, exp);
    end
  endtask

  task automatic check_all();
    chk(fetch_req == exp_req(), "R3", fetch_req, exp_req());
    chk(out_pix == m_out, "R2", out_pix, m_out);
    chk(ovf_flag == m_ovf, "R6", ovf_flag, m_ovf);
    chk(unf_flag == m_unf, "R7", unf_flag, m_unf);
    chk(unf_pulse == m_pls, "R8", unf_pulse, m_pls);
    chk(in_ready == en, "R12", in_ready, en);
  endtask

  // one clock: update model from pre-edge state, clock, check, drop strobes
  task automatic step();
    bit flush, swc, gate, take, empty, fits;
    int occ0;
    swc   = !en && fifo_clr;
    flush = swc || (cfg_clr_sof && frame_start);
    gate  = en && (m_arm || !cfg_wait_hs);
    take  = pop && gate && !flush;
    empty = (mq.size() == 0);
    occ0  = m_occ;
    fits  = (occ0 + slices(cfg_fmt)) <= CAP;
    if (pop) m_out = (take && !empty) ? mq[0][23:0] : FILL;
    m_pls = take && empty && cfg_unf_trig;
    m_unf = swc ? 1'b0 : (m_unf || (take && empty));
    m_ovf = swc ? 1'b0 : (m_ovf || (in_valid && en && !flush && !fits));
    if (flush) begin
      mq.delete();
      m_occ = 0;
    end else begin
      if (take && !empty) begin
        m_occ -= slices(mq[0][25:24]);
        void'(mq.pop_front());
      end
      if (in_valid && en && fits) begin
        mq.push_back({cfg_fmt, in_pix});
        m_occ += slices(cfg_fmt);
      end
    end
    m_arm = !en ? 1'b0 : (hstart ? 1'b1 : m_arm);
    @(posedge clk);
    @(negedge clk);
    check_all();
    in_valid = 0; pop = 0; hstart = 0; frame_start = 0; fifo_clr = 0;
  endtask

  task automatic push(input logic [23:0] d);
    in_valid = 1; in_pix = d; step();
  endtask

  task automatic do_pop();
    pop = 1; step();
  endtask

  task automatic hard_clear();
    en = 0; fifo_clr = 1; step(); en = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    en = 0; cfg_fmt = 2; cfg_lvl_auto = 1; cfg_lvl_lo = 0; cfg_lvl_hi = 0;
    cfg_clr_sof = 0; cfg_wait_hs = 0; cfg_unf_trig = 0;
    fifo_clr = 0; frame_start = 0; hstart = 0; in_valid = 0; pop = 0; in_pix = 0;
    m_occ = 0; m_ovf = 0; m_unf = 0; m_pls = 0; m_arm = 0; m_out = FILL;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    ctx_tag = "R1";
    chk(fetch_req == 0, "R1", fetch_req, 0);
    chk(in_ready == 0, "R1", in_ready, 0);
    chk(out_pix == FILL, "R1", out_pix, FILL);
    chk(!ovf_flag && !unf_flag && !unf_pulse, "R1", {ovf_flag, unf_flag, unf_pulse}, 0);

    // R12 disabled: push ignored, pop gives fill without underflow
    ctx_tag = "R12";
    push(24'hABCDEF);
    do_pop();
    chk(out_pix == FILL && !unf_flag, "R12", out_pix, FILL);

    // R4 auto level for 24-bit: 45 bytes
    en = 1; ctx_tag = "R4";
    for (int i = 0; i < 14; i++) push(24'h100 + 24'(i));
    chk(fetch_req == 1, "R4", fetch_req, 1);
    push(24'h1FF);
    chk(fetch_req == 0, "R4", fetch_req, 0);
    // R2 order
    ctx_tag = "R2";
    do_pop();
    chk(out_pix == 24'h100, "R2", out_pix, 24'h100);
    hard_clear();

    // R4 16-bit level 52, R3 rounding with 18-bit packed (level 50)
    cfg_fmt = 0; ctx_tag = "R4";
    for (int i = 0; i < 26; i++) push(24'h200 + 24'(i));
    chk(fetch_req == 0, "R4", fetch_req, 0);
    hard_clear();
    cfg_fmt = 1; ctx_tag = "R3";
    for (int i = 0; i < 21; i++) push(24'h300 + 24'(i));
    chk(fetch_req == 1, "R3", fetch_req, 1);
    push(24'h3FF);
    chk(fetch_req == 0, "R3", fetch_req, 0);
    hard_clear();

    // R5 manual level: high field makes 69, low only makes 10
    cfg_fmt = 0; cfg_lvl_auto = 0; cfg_lvl_hi = 1; cfg_lvl_lo = 6'd5; ctx_tag = "R5";
    for (int i = 0; i < 32; i++) push(24'h400 + 24'(i));
    chk(fetch_req == 1, "R5", fetch_req, 1);
    hard_clear();
    cfg_lvl_hi = 0; cfg_lvl_lo = 6'd10;
    for (int i = 0; i < 4; i++) push(24'h500 + 24'(i));
    chk(fetch_req == 1, "R5", fetch_req, 1);
    push(24'h5FF);
    chk(fetch_req == 0, "R5", fetch_req, 0);
    hard_clear();
    cfg_lvl_auto = 1;

    // R6 overflow: 21 x 24-bit fill 252 slices, the 22nd is dropped
    cfg_fmt = 2; ctx_tag = "R6";
    for (int i = 0; i < 22; i++) push(24'h600 + 24'(i));
    chk(ovf_flag == 1, "R6", ovf_flag, 1);
    for (int i = 0; i < 21; i++) begin
      do_pop();
      chk(out_pix == 24'h600 + 24'(i), "R6", out_pix, 24'h600 + 24'(i));
    end

    // R7/R8 underflow with and without event
    ctx_tag = "R7";
    do_pop();
    chk(out_pix == FILL && unf_flag && !unf_pulse, "R7", out_pix, FILL);
    cfg_unf_trig = 1; ctx_tag = "R8";
    do_pop();
    chk(unf_pulse == 1, "R8", unf_pulse, 1);
    step();
    chk(unf_pulse == 0, "R8", unf_pulse, 0);
    ctx_tag = "R7";
    push(24'h777);
    do_pop();
    chk(out_pix == 24'h777, "R7", out_pix, 24'h777);

    // R9 clear ignored while enabled, honoured when disabled
    ctx_tag = "R9";
    push(24'h999);
    fifo_clr = 1; step();
    chk(ovf_flag && unf_flag, "R9", {ovf_flag, unf_flag}, 3);
    do_pop();
    chk(out_pix == 24'h999, "R9", out_pix, 24'h999);
    push(24'h99A);
    hard_clear();
    chk(!ovf_flag && !unf_flag, "R9", {ovf_flag, unf_flag}, 0);
    cfg_unf_trig = 0;
    do_pop();
    chk(out_pix == FILL, "R9", out_pix, FILL);
    hard_clear();

    // R10 frame-start flush only when selected
    ctx_tag = "R10";
    push(24'hA01);
    frame_start = 1; step();
    do_pop();
    chk(out_pix == 24'hA01, "R10", out_pix, 24'hA01);
    push(24'hA02);
    cfg_clr_sof = 1; frame_start = 1; step();
    cfg_clr_sof = 0;
    do_pop();
    chk(out_pix == FILL, "R10", out_pix, FILL);
    hard_clear();

    // R11 wait for horizontal start
    ctx_tag = "R11";
    en = 0; step();
    cfg_wait_hs = 1; en = 1;
    push(24'hB01);
    push(24'hB02);
    do_pop();
    chk(out_pix == FILL && !unf_flag, "R11", out_pix, FILL);
    hstart = 1; step();
    do_pop();
    chk(out_pix == 24'hB01, "R11", out_pix, 24'hB01);
    cfg_wait_hs = 0;
    hard_clear();

    // random traffic
    ctx_tag = "RND";
    for (int n = 0; n < 4000; n++) begin
      in_valid = ($urandom % 3) != 0;
      in_pix   = 24'($urandom);
      pop      = ($urandom % 5) < 2;
      if ($urandom % 40 == 0) cfg_fmt = 2'($urandom);
      if ($urandom % 60 == 0) hstart = 1;
      if ($urandom % 300 == 0) begin cfg_clr_sof = 1'($urandom); frame_start = 1; end
      if ($urandom % 400 == 0) en = ~en;
      if ($urandom % 150 == 0) fifo_clr = 1;
      if ($urandom % 200 == 0) cfg_wait_hs = 1'($urandom);
      if ($urandom % 200 == 0) cfg_unf_trig = 1'($urandom);
      if ($urandom % 500 == 0) begin
        cfg_lvl_auto = 1'($urandom); cfg_lvl_lo = 6'($urandom); cfg_lvl_hi = 1'($urandom);
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule